// File: doc/BRIEF.md
# Start-Up Delay Sequencer

This block keeps a processor core stopped after any reset event until the supply and the oscillator have had time to settle. Two timers run one after the other. The first is a supply-settle timer clocked by ticks from a free-running low-frequency oscillator. The second is an oscillator-settle counter clocked by the core oscillator itself. Which timers run depends on the cause of the reset (power-on, brown-out or wake from sleep), on the oscillator mode (crystal-type or RC) and on a configuration enable for the supply-settle timer.

The external active-low reset pin passes through a synchroniser. It gates the run output separately from the timers. The timers therefore keep counting from power-on while the pin is held low. A pin released after the timers have expired lets the core start after the synchroniser latency alone. Pulling the pin low while a sequence is still running restarts that sequence from its first stage. Both delays are parameters, so a simulation can shorten them.

The single clock `clk_i` is the core oscillator. `lf_tick_i` is a one-cycle pulse per low-frequency period, already brought into this domain. `por_i` is the power-on pulse and acts as the asynchronous reset.

Top module: `startup_delay_seq`

## Requirements
- R1: While `por_i` is high, `core_run_o` is 0. After release it stays 0 until every delay that applies has run out.
- R2: After power-on in crystal mode (`osc_rc_i`=0) with the supply timer enabled (`pwrup_tmr_en_i`=1), the sequence takes one arm cycle, then PWRUP_TICKS ticks, then OSC_CYCLES cycles. `core_run_o` goes to 1 after the clock edge numbered 1+PWRUP_TICKS+OSC_CYCLES, counting edges from the release of `por_i`.
- R3: The supply-settle stage advances only on cycles with `lf_tick_i`=1. With no ticks, `core_run_o` stays 0 indefinitely. Once ticks arrive at one per cycle, the stage ends after PWRUP_TICKS of them, and the oscillator stage follows.
- R4: In RC mode (`osc_rc_i`=1) the oscillator-settle stage is skipped for every reset cause.
- R5: With `pwrup_tmr_en_i`=0 only the oscillator stage applies after power-on. In RC mode with the timer disabled, `core_run_o` rises as soon as the 2-stage synchroniser delivers a released pin, after edge 2.
- R6: A cycle with `brownout_i`=1 forces `core_run_o` to 0 from the next edge. It restarts the full power-on chain for the current configuration, which ends 1+(PWRUP_TICKS if enabled)+(OSC_CYCLES if crystal) edges after the edge that sampled it.
- R7: `wake_i`=1 while the core runs starts only the oscillator stage in crystal mode: `core_run_o` is 0 for OSC_CYCLES edges and returns after edge OSC_CYCLES. In RC mode a wake has no effect on `core_run_o`.
- R8: `wake_i` sampled while a sequence is running is ignored, and the completion time does not change.
- R9: `ext_rst_n_i` reaches the logic through two flops. `core_run_o` follows a low or high pin two edges later. Timers keep counting while the pin is low, so a release after expiry gives `core_run_o`=1 after edge 2.
- R10: A falling pin seen while a sequence runs sends it back to the arm cycle. For the crystal, timer-enabled chain with the pin driven low after edge k, `core_run_o` rises after edge k+4+PWRUP_TICKS+OSC_CYCLES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core oscillator clock |
| por_i | input | 1 | Power-on pulse, asynchronous active-high reset |
| brownout_i | input | 1 | Brown-out detect, synchronous active-high |
| wake_i | input | 1 | Wake-from-sleep request, one-cycle pulse |
| ext_rst_n_i | input | 1 | External reset pin, active low, asynchronous |
| osc_rc_i | input | 1 | Oscillator mode: 1 = RC, 0 = crystal-type |
| pwrup_tmr_en_i | input | 1 | 1 = supply-settle timer enabled |
| lf_tick_i | input | 1 | One pulse per low-frequency clock period |
| core_run_o | output | 1 | 1 = core released from reset |

## Verification
The bench measures exact release edges for all four mode and enable combinations. An off-by-one count in either counter, or a missing arm cycle, therefore shows up as a wrong latency. It holds the tick input at 0 to catch a supply timer that counts oscillator cycles: such a design would release the core early. A pin held low across expiry and released late must give a two-edge release; a design that paused its timers under the pin would instead take the whole chain again. Wake pulses mid-sequence and pin assertions mid-sequence check that the first is ignored and the second restarts, and a brown-out in RC mode checks that no oscillator stage is inserted.

// File: rtl/sds_pkg.sv
package sds_pkg;

   typedef enum logic [1:0] {
      ST_ARM        = 2'd0,
      ST_PWRUP_WAIT = 2'd1,
      ST_OSC_WAIT   = 2'd2,
      ST_RUN        = 2'd3
   } sds_state_e;

   typedef enum logic {
      CAUSE_FULL = 1'b0,
      CAUSE_WAKE = 1'b1
   } sds_cause_e;

endpackage

// File: rtl/sds_sync.sv
module sds_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic d_i,
   output logic q_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("sds_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk_i or posedge rst_i) begin
               if (rst_i) chain_q[s] <= 1'b0;
               else       chain_q[s] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk_i or posedge rst_i) begin
               if (rst_i) chain_q[s] <= 1'b0;
               else       chain_q[s] <= chain_q[s-1];
            end
         end
      end
   endgenerate

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/sds_timer.sv
module sds_timer #(
   parameter int unsigned LIMIT = 16
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic clr_i,
   input  logic step_i,
   output logic expire_o
);
   generate
      if (LIMIT < 1) begin : g_bad_limit
         $error("sds_timer: LIMIT must be at least 1");
      end

      if (LIMIT == 1) begin : g_single
         assign expire_o = step_i & ~clr_i;
      end else begin : g_count
         localparam int unsigned CNT_W = $clog2(LIMIT);
         localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

         logic [CNT_W-1:0] cnt_q;
         logic             at_last;

         assign at_last = (cnt_q == LAST);

         always_ff @(posedge clk_i or posedge rst_i) begin
            if (rst_i)       cnt_q <= '0;
            else if (clr_i)  cnt_q <= '0;
            else if (step_i) cnt_q <= at_last ? '0 : cnt_q + 1'b1;
         end

         assign expire_o = step_i & ~clr_i & at_last;
      end
   endgenerate
endmodule

// File: rtl/sds_fsm.sv
module sds_fsm
   import sds_pkg::*;
(
   input  logic       clk_i,
   input  logic       rst_i,
   input  logic       brownout_i,
   input  logic       wake_i,
   input  logic       osc_rc_i,
   input  logic       pwrup_en_i,
   input  logic       ext_ok_i,
   input  logic       pwrup_exp_i,
   input  logic       osc_exp_i,
   output sds_state_e state_o
);
   sds_state_e state_q, state_d;
   sds_cause_e cause_q, cause_d;
   logic       ext_prev_q;
   logic       ext_fall;

   // a fresh assertion of the external pin, seen after synchronisation
   assign ext_fall = ext_prev_q & ~ext_ok_i;

   always_comb begin
      state_d = state_q;
      cause_d = cause_q;
      case (state_q)
         ST_ARM: begin
            if (cause_q == CAUSE_FULL && pwrup_en_i) state_d = ST_PWRUP_WAIT;
            else if (osc_rc_i)                       state_d = ST_RUN;
            else                                     state_d = ST_OSC_WAIT;
         end
         ST_PWRUP_WAIT: begin
            if (pwrup_exp_i) state_d = osc_rc_i ? ST_RUN : ST_OSC_WAIT;
         end
         ST_OSC_WAIT: begin
            if (osc_exp_i) state_d = ST_RUN;
         end
         ST_RUN: begin
            if (wake_i && !osc_rc_i) begin
               state_d = ST_OSC_WAIT;
               cause_d = CAUSE_WAKE;
            end
         end
         default: state_d = ST_ARM;
      endcase

      // pin asserted mid-sequence: restart the current chain
      if (ext_fall && state_q != ST_RUN) state_d = ST_ARM;

      // brown-out dominates and always selects the full chain
      if (brownout_i) begin
         state_d = ST_ARM;
         cause_d = CAUSE_FULL;
      end
   end

   always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i) begin
         state_q    <= ST_ARM;
         cause_q    <= CAUSE_FULL;
         ext_prev_q <= 1'b0;
      end else begin
         state_q    <= state_d;
         cause_q    <= cause_d;
         ext_prev_q <= ext_ok_i;
      end
   end

   assign state_o = state_q;
endmodule

// File: rtl/startup_delay_seq.sv
module startup_delay_seq
   import sds_pkg::*;
#(
   parameter int unsigned PWRUP_TICKS = 72,
   parameter int unsigned OSC_CYCLES  = 1024,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk_i,
   input  logic por_i,
   input  logic brownout_i,
   input  logic wake_i,
   input  logic ext_rst_n_i,
   input  logic osc_rc_i,
   input  logic pwrup_tmr_en_i,
   input  logic lf_tick_i,
   output logic core_run_o
);
   sds_state_e seq_state;
   logic       ext_ok;
   logic       pwrup_step, pwrup_clr, pwrup_exp;
   logic       osc_step, osc_clr, osc_exp;

   sds_sync #(.STAGES(SYNC_STAGES)) u_pin_sync (
      .clk_i (clk_i),
      .rst_i (por_i),
      .d_i   (ext_rst_n_i),
      .q_o   (ext_ok)
   );

   assign pwrup_step = (seq_state == ST_PWRUP_WAIT) & lf_tick_i;
   assign pwrup_clr  = (seq_state != ST_PWRUP_WAIT);
   assign osc_step   = (seq_state == ST_OSC_WAIT);
   assign osc_clr    = (seq_state != ST_OSC_WAIT);

   sds_timer #(.LIMIT(PWRUP_TICKS)) u_pwrup_tmr (
      .clk_i    (clk_i),
      .rst_i    (por_i),
      .clr_i    (pwrup_clr),
      .step_i   (pwrup_step),
      .expire_o (pwrup_exp)
   );

   sds_timer #(.LIMIT(OSC_CYCLES)) u_osc_tmr (
      .clk_i    (clk_i),
      .rst_i    (por_i),
      .clr_i    (osc_clr),
      .step_i   (osc_step),
      .expire_o (osc_exp)
   );

   sds_fsm u_fsm (
      .clk_i       (clk_i),
      .rst_i       (por_i),
      .brownout_i  (brownout_i),
      .wake_i      (wake_i),
      .osc_rc_i    (osc_rc_i),
      .pwrup_en_i  (pwrup_tmr_en_i),
      .ext_ok_i    (ext_ok),
      .pwrup_exp_i (pwrup_exp),
      .osc_exp_i   (osc_exp),
      .state_o     (seq_state)
   );

   // pin gating is independent of the timers
   assign core_run_o = (seq_state == ST_RUN) & ext_ok;
endmodule

// File: rtl/startup_delay_seq_chk.sv
module startup_delay_seq_chk
   import sds_pkg::*;
(
   input logic       clk_i,
   input logic       por_i,
   input logic       brownout_i,
   input logic       wake_i,
   input logic       ext_rst_n_i,
   input logic       osc_rc_i,
   input logic       lf_tick_i,
   input logic       core_run_o,
   input sds_state_e state_i
);
   p_brownout_stops_r6: assert property (@(posedge clk_i) disable iff (por_i)
      brownout_i |=> !core_run_o);

   p_pin_gates_run_r9: assert property (@(posedge clk_i) disable iff (por_i)
      !$past(ext_rst_n_i, 2) |-> !core_run_o);

   p_wake_crystal_r7: assert property (@(posedge clk_i) disable iff (por_i)
      (core_run_o && wake_i && !osc_rc_i && !brownout_i) |=> !core_run_o);

   p_tick_gated_r3: assert property (@(posedge clk_i) disable iff (por_i)
      (state_i == ST_PWRUP_WAIT && !lf_tick_i && !brownout_i)
      |=> (state_i == ST_PWRUP_WAIT || state_i == ST_ARM));

   p_skip_osc_only_rc_r4: assert property (@(posedge clk_i) disable iff (por_i)
      ($rose(core_run_o) && $past(state_i) == ST_PWRUP_WAIT) |-> osc_rc_i);
endmodule

bind startup_delay_seq startup_delay_seq_chk i_chk (
   .clk_i       (clk_i),
   .por_i       (por_i),
   .brownout_i  (brownout_i),
   .wake_i      (wake_i),
   .ext_rst_n_i (ext_rst_n_i),
   .osc_rc_i    (osc_rc_i),
   .lf_tick_i   (lf_tick_i),
   .core_run_o  (core_run_o),
   .state_i     (seq_state)
);

// File: tb/test_startup_delay_seq.sv
module test_startup_delay_seq;
   localparam int CLK_PERIOD = 10;
   localparam int P = 24;
   localparam int O = 40;

   // columns: osc_rc, timer enable, expected release edge after power-on
   localparam int VEC [4][3] = '{
      '{0, 1, 1 + P + O},
      '{1, 1, 1 + P},
      '{0, 0, 1 + O},
      '{1, 0, 2}
   };

   logic clk = 1'b0, por = 1'b1, bor = 1'b0, wake = 1'b0;
   logic ext_n = 1'b1, rc = 1'b0, pw = 1'b1, tick = 1'b1;
   wire  core_run;
   int   total = 0, bad = 0;

   startup_delay_seq #(.PWRUP_TICKS(P), .OSC_CYCLES(O)) i_startup_delay_seq (
      .clk_i(clk), .por_i(por), .brownout_i(bor), .wake_i(wake),
      .ext_rst_n_i(ext_n), .osc_rc_i(rc), .pwrup_tmr_en_i(pw),
      .lf_tick_i(tick), .core_run_o(core_run));

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input string req, input int act, input int expv);
      total++;
      if (act != expv) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   task automatic power_on(input logic rc_v, input logic pw_v);
      @(negedge clk);
      por = 1'b1; rc = rc_v; pw = pw_v; wake = 1'b0; bor = 1'b0;
      repeat (2) @(negedge clk);
      por = 1'b0;
   endtask

   task automatic run_latency(input int wake_at, input int ext_at,
                              input int ext_len, output int n);
      n = 0;
      for (int i = 0; i < 5000; i++) begin
         @(posedge clk);
         n++;
         @(negedge clk);
         if (core_run) return;
         if (n == wake_at)     wake = 1'b1;
         if (n == wake_at + 1) wake = 1'b0;
         if (n == ext_at)      ext_n = 1'b0;
         if (n == ext_at + ext_len) ext_n = 1'b1;
      end
      n = -1;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      bad++;
      $display("FAIL watchdog expired actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int n;
      int lows;
      // R1: held in reset while power-on pulse is high
      repeat (3) @(negedge clk);
      check("R1 reset state", core_run, 0);
      por = 1'b0;

      // table walk: R2 crystal full chain, R4 RC skip, R5 timer disabled
      for (int v = 0; v < 4; v++) begin
         power_on(VEC[v][0] != 0, VEC[v][1] != 0);
         run_latency(-1, -1, 0, n);
         check($sformatf("R2/R4/R5 por latency vec%0d", v), n, VEC[v][2]);
      end

      // R3: supply timer needs ticks
      tick = 1'b0;
      power_on(1'b0, 1'b1);
      repeat (200) @(negedge clk);
      check("R3 no ticks holds reset", core_run, 0);
      tick = 1'b1;
      run_latency(-1, -1, 0, n);
      check("R3 ticks resume", n, P + O);

      // R6: brown-out, crystal full chain
      @(negedge clk);
      bor = 1'b1;
      @(posedge clk); @(negedge clk);
      bor = 1'b0;
      check("R6 brownout drops run", core_run, 0);
      run_latency(-1, -1, 0, n);
      check("R6 brownout crystal latency", n, 1 + P + O);

      // R6 + R4: brown-out in RC mode
      power_on(1'b1, 1'b1);
      run_latency(-1, -1, 0, n);
      @(negedge clk);
      bor = 1'b1;
      @(posedge clk); @(negedge clk);
      bor = 1'b0;
      run_latency(-1, -1, 0, n);
      check("R6 R4 brownout rc latency", n, 1 + P);

      // R7: wake in crystal mode
      power_on(1'b0, 1'b0);
      run_latency(-1, -1, 0, n);
      @(negedge clk);
      wake = 1'b1;
      @(posedge clk); @(negedge clk);
      wake = 1'b0;
      check("R7 wake crystal drops run", core_run, 0);
      run_latency(-1, -1, 0, n);
      check("R7 wake crystal latency", n, O);

      // R7: wake in RC mode has no effect
      power_on(1'b1, 1'b0);
      run_latency(-1, -1, 0, n);
      @(negedge clk);
      wake = 1'b1;
      lows = 0;
      for (int c = 0; c < 6; c++) begin
         @(posedge clk); @(negedge clk);
         wake = 1'b0;
         if (!core_run) lows++;
      end
      check("R7 wake rc keeps run", lows, 0);

      // R8: wake during a running sequence is ignored
      power_on(1'b0, 1'b1);
      run_latency(5, -1, 0, n);
      check("R8 wake mid-sequence", n, 1 + P + O);

      // R10: pin assertion mid-sequence restarts
      power_on(1'b0, 1'b1);
      run_latency(-1, 10, 3, n);
      check("R10 pin restart latency", n, 10 + 4 + P + O);

      // R9: pin low while running, two-edge latency both ways
      @(negedge clk);
      ext_n = 1'b0;
      @(posedge clk); @(negedge clk);
      check("R9 pin low first edge", core_run, 1);
      @(posedge clk); @(negedge clk);
      check("R9 pin low second edge", core_run, 0);
      ext_n = 1'b1;
      run_latency(-1, -1, 0, n);
      check("R9 pin release latency", n, 2);

      // R9: pin held low across expiry, late release
      ext_n = 1'b0;
      power_on(1'b0, 1'b1);
      repeat (100) @(negedge clk);
      check("R9 pin held low", core_run, 0);
      ext_n = 1'b1;
      run_latency(-1, -1, 0, n);
      check("R9 late release immediate", n, 2);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule